// File: doc/BRIEF.md
# I2C Register-Write Record and Replay Buffer

This block sits between a byte-level I2C slave engine and a byte-level I2C master engine. It is used to set up a group of identical sensors from one host. In the first phase the host writes configuration to the slave side. Each register write is four bytes: a 16-bit register address and then 16-bit data. The block packs each write into one 32-bit word and stores it in a small memory. The memory only needs to be as deep as the number of writes the host makes, not the 16-bit register space, so no address translation is needed.

In the second phase a start pulse begins replay. For each 7-bit device address in a parameter list, the block drives the master engine through the recorded writes in capture order. Each write is one transaction: START, the device address with the write bit, the four bytes, then STOP. A NACK from a device raises a sticky error flag and moves replay on to the next device. A done flag marks the end of replay.

Top module: `i2c_cfg_replay`

## Requirements
- R1: While idle, four slave bytes are packed into one entry in arrival order: address high, address low, data high, data low. The entry count rises by one on the fourth byte.
- R2: A slave STOP (`s_stop`) seen before the fourth byte discards the bytes gathered so far. The next byte starts a new entry. If a byte and a STOP come in the same cycle, the STOP wins.
- R3: When the count equals DEPTH, later complete entries are dropped and `overflow` is set. `overflow` stays set, the count stays at DEPTH, and dropped entries are never replayed.
- R4: `clear` while idle sets the count to zero and clears `overflow`, `done`, `nack_err` and any partial entry.
- R5: Each replayed write is five master bytes. The first byte is `{device_address, 1'b0}` with `m_start`=1. It is followed by address high, address low, data high, then data low, and the last byte has `m_stop`=1. Entries are replayed in capture order.
- R6: Replay sends the whole entry list to target 0 first, then to target 1, and so on. Target k is `TGT_ADDRS[7k+6:7k]`.
- R7: A byte completed with `m_nack`=1 sets the sticky `nack_err`. No further bytes go to that target, and replay continues with entry 0 of the next target.
- R8: `done` rises and `busy` falls in the cycle after the final byte to the last target completes. `replay_start` with zero entries sets `done` one cycle later and issues no request. `done` is cleared by the next `replay_start` or by `clear`.
- R9: While `m_req` is high and `m_done` is low, `m_req`, `m_byte`, `m_start` and `m_stop` hold their values.
- R10: While `busy`, slave bytes, slave STOPs, `clear` and `replay_start` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Empties the buffer and clears the flags |
| s_byte_valid | input | 1 | A byte was received by the slave engine |
| s_byte | input | 8 | The received byte |
| s_stop | input | 1 | The slave engine saw a STOP |
| replay_start | input | 1 | Begins replay |
| m_req | output | 1 | A byte is offered to the master engine |
| m_start | output | 1 | Send a START before this byte |
| m_stop | output | 1 | Send a STOP after this byte |
| m_byte | output | 8 | Byte for the master engine |
| m_done | input | 1 | The master finished the offered byte |
| m_nack | input | 1 | The finished byte was not acknowledged |
| count | output | $clog2(DEPTH+1) | Number of stored entries |
| busy | output | 1 | Replay in progress |
| done | output | 1 | Replay finished |
| nack_err | output | 1 | Sticky NACK flag |
| overflow | output | 1 | Sticky dropped-entry flag |

## Verification
Capture is tried with complete quads, with a STOP after two bytes, with a clear after one byte, and with more writes than the memory holds. Together these separate byte packing order from partial discard and from the full-memory drop. Replay is tried with a clean run over two targets, which shows entry order and target order. It is also tried with a NACK in the middle of one entry of target 0, which shows that the rest of that target is skipped and the next target still gets the full list. Replay from an empty buffer checks that `done` comes without any request. Slave traffic injected during replay checks that capture is frozen while busy.

// File: rtl/i2c_cfg_replay.sv
module i2c_cfg_replay #(
  parameter int DEPTH = 8,
  parameter int NUM_TGT = 2,
  parameter logic [NUM_TGT*7-1:0] TGT_ADDRS = {7'h5A, 7'h48},
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TW = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          s_byte_valid,
  input  logic [7:0]    s_byte,
  input  logic          s_stop,
  input  logic          replay_start,
  output logic          m_req,
  output logic          m_start,
  output logic          m_stop,
  output logic [7:0]    m_byte,
  input  logic          m_done,
  input  logic          m_nack,
  output logic [CW-1:0] count,
  output logic          busy,
  output logic          done,
  output logic          nack_err,
  output logic          overflow
);
  logic [31:0]   mem [DEPTH];
  logic [1:0]    bc;
  logic [23:0]   acc;
  logic [TW-1:0] tgt;
  logic [CW-1:0] ent;
  logic [2:0]    bi;
  logic [31:0]   word;

  wire idle_cmd = !busy && !clear;
  wire quad_end = idle_cmd && !s_stop && s_byte_valid && bc == 2'd3;
  wire wr_en    = quad_end && count < CW'(DEPTH);
  wire last_ent = CW'(ent + 1'b1) == count;
  wire last_tgt = int'(tgt) == NUM_TGT - 1;

  assign word    = mem[ent[AW-1:0]];
  assign m_req   = busy;
  assign m_start = bi == 3'd0;
  assign m_stop  = bi == 3'd4;

  always_comb
    case (bi)
      3'd0:    m_byte = {TGT_ADDRS[int'(tgt)*7 +: 7], 1'b0};
      3'd1:    m_byte = word[31:24];
      3'd2:    m_byte = word[23:16];
      3'd3:    m_byte = word[15:8];
      default: m_byte = word[7:0];
    endcase

  always_ff @(posedge clk)
    if (wr_en) mem[count[AW-1:0]] <= {acc, s_byte};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0; bc <= '0; acc <= '0; overflow <= 1'b0;
      busy <= 1'b0; done <= 1'b0; nack_err <= 1'b0;
      tgt <= '0; ent <= '0; bi <= '0;
    end else if (!busy) begin
      if (clear) begin
        count <= '0; bc <= '0; overflow <= 1'b0;
        done <= 1'b0; nack_err <= 1'b0;
      end else begin
        if (s_stop) bc <= '0;
        else if (s_byte_valid) begin
          if (bc == 2'd3) begin
            bc <= '0;
            if (wr_en) count <= count + 1'b1;
            else overflow <= 1'b1;
          end else begin
            acc <= {acc[15:0], s_byte};
            bc  <= bc + 1'b1;
          end
        end
        if (replay_start) begin
          done <= 1'b0; nack_err <= 1'b0;
          tgt <= '0; ent <= '0; bi <= '0;
          if (count == '0) done <= 1'b1;
          else busy <= 1'b1;
        end
      end
    end else if (m_done) begin
      if (m_nack) nack_err <= 1'b1;
      if (m_nack || (bi == 3'd4 && last_ent)) begin
        bi <= '0; ent <= '0;
        if (last_tgt) begin
          busy <= 1'b0; done <= 1'b1;
        end else tgt <= tgt + 1'b1;
      end else if (bi == 3'd4) begin
        bi <= '0; ent <= ent + 1'b1;
      end else bi <= bi + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_cfg_replay_chk.sv
module i2c_cfg_replay_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear,
  input logic          m_req,
  input logic          m_start,
  input logic          m_stop,
  input logic [7:0]    m_byte,
  input logic          m_done,
  input logic [CW-1:0] count,
  input logic          busy,
  input logic          done,
  input logic          overflow
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_done |=> m_req && $stable(m_byte) && $stable(m_start) && $stable(m_stop)); // R9
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clear |=> overflow); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !m_req); // R8
  AST_START_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && m_start |-> !m_byte[0] && !m_stop); // R5
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(count)); // R10
endmodule

bind i2c_cfg_replay i2c_cfg_replay_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .m_req(m_req), .m_start(m_start),
  .m_stop(m_stop), .m_byte(m_byte), .m_done(m_done), .count(count),
  .busy(busy), .done(done), .overflow(overflow));

// File: tb/i2c_cfg_replay_test.sv
module i2c_cfg_replay_test;
  localparam int DEPTH = 4;
  localparam int NT = 2;
  localparam logic [13:0] TG = {7'h33, 7'h12};
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, clear = 0, s_byte_valid = 0, s_stop = 0, replay_start = 0;
  logic [7:0] s_byte = 0;
  logic m_req, m_start, m_stop, m_done = 0, m_nack = 0;
  logic [7:0] m_byte;
  logic [CW-1:0] count;
  logic busy, done, nack_err, overflow;

  int errors = 0, checks = 0;
  logic [31:0] mdl_mem[$];
  int mdl_part = 0;
  logic [23:0] mdl_acc;
  bit mdl_ovf = 0;
  logic [9:0] exp_q[$];
  int served = 0, nack_at = -1;

  always #2.5 clk = ~clk;

  i2c_cfg_replay #(.DEPTH(DEPTH), .NUM_TGT(NT), .TGT_ADDRS(TG)) uut (.*);

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (m_done) begin
      m_done = 0; m_nack = 0;
    end else if (m_req) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5: actual=%0h expected=none", {m_stop, m_start, m_byte});
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        if ({m_stop, m_start, m_byte} != e) begin
          errors++;
          $display("FAIL R5/R6: actual=%0h expected=%0h", {m_stop, m_start, m_byte}, e);
        end
      end
      m_nack = (served == nack_at);
      served++;
      m_done = 1;
    end
  end

  task automatic put_byte(logic [7:0] b);
    @(negedge clk); s_byte_valid = 1; s_byte = b;
    @(negedge clk); s_byte_valid = 0;
    if (mdl_part == 3) begin
      mdl_part = 0;
      if (mdl_mem.size() < DEPTH) mdl_mem.push_back({mdl_acc, b});
      else mdl_ovf = 1;
    end else begin
      mdl_acc = {mdl_acc[15:0], b};
      mdl_part++;
    end
  endtask

  task automatic put_entry(logic [31:0] w);
    for (int i = 3; i >= 0; i--) put_byte(w[i*8 +: 8]);
  endtask

  task automatic put_stop();
    @(negedge clk); s_stop = 1;
    @(negedge clk); s_stop = 0;
    mdl_part = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
    mdl_mem.delete(); mdl_part = 0; mdl_ovf = 0;
  endtask

  task automatic chk_status(string r);
    chk(r, int'(count), mdl_mem.size());
    chk(r, int'(overflow), int'(mdl_ovf));
  endtask

  task automatic replay(int nt, int ne, int nk, bit intrude, string r);
    int idx = 0, nidx = -1, w = 0;
    exp_q.delete();
    for (int t = 0; t < NT; t++) begin : tl
      for (int e = 0; e < mdl_mem.size(); e++) begin
        for (int k = 0; k < 5; k++) begin
          logic [7:0] b;
          b = (k == 0) ? {TG[t*7 +: 7], 1'b0} : mdl_mem[e][(4-k)*8 +: 8];
          exp_q.push_back({k == 4, k == 0, b});
          if (t == nt && e == ne && k == nk) begin
            nidx = idx; idx++;
            disable tl;
          end
          idx++;
        end
      end
    end
    served = 0; nack_at = nidx;
    @(negedge clk); replay_start = 1;
    @(negedge clk); replay_start = 0;
    if (intrude) begin
      s_byte_valid = 1; s_byte = 8'hEE; clear = 1;
      repeat (5) @(negedge clk);
      s_byte_valid = 0; clear = 0;
      chk("R10", int'(busy), 1);
      chk("R10", int'(count), mdl_mem.size());
    end
    while (!done && w < 2000) begin @(negedge clk); w++; end
    chk(r, int'(done), 1);
    chk(r, int'(busy), 0);
    chk(r, exp_q.size(), 0);
    chk("R7", int'(nack_err), int'(nidx >= 0));
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset", int'(count), 0);
    chk("R8 reset", int'({busy, done, m_req, nack_err, overflow}), 0);

    put_entry(32'h12AB_C0DE);
    put_entry(32'h0003_8001);
    chk_status("R1");

    put_byte(8'h77); put_byte(8'h66);
    put_stop();
    chk_status("R2");
    put_entry(32'hFF10_5A5A);
    chk_status("R2");

    replay(-1, -1, -1, 0, "R6");
    replay(0, 1, 2, 1, "R7");
    chk_status("R10");

    put_entry(32'h4444_0004);
    put_entry(32'h5555_0005);
    chk_status("R3");
    chk("R3", int'(overflow), 1);
    replay(-1, -1, -1, 0, "R3");

    do_clear();
    chk_status("R4");
    chk("R4", int'(done), 0);
    @(negedge clk); replay_start = 1;
    @(negedge clk); replay_start = 0;
    chk("R8 empty", int'(done), 1);
    chk("R8 empty", int'(m_req), 0);

    put_byte(8'h99);
    do_clear();
    put_entry(32'hA1B2_C3D4);
    chk_status("R4");
    replay(1, 0, 0, 0, "R4");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule